// File: doc/BRIEF.md
# Four-Bit Function-Select ALU with Hex Display Front End

This block is a purely combinational arithmetic logic unit. It takes two 4-bit operands and a 3-bit function code and returns an 8-bit result. A small structural ripple-carry adder is built from gate-level full adders. These full adders use no addition operator. Two copies of the adder serve the increment and add functions. A second add path uses the language operator, so the two add implementations can be compared against each other.

A thin front end sits around the ALU core. It takes the function code from three active-low pushbuttons and inverts them. It also drives six seven-segment digits: the two operands, the two result nibbles, and two digits that always show zero. The block has no clock and no state. Each function code is a fixed path through the result multiplexer:

- **OP_INC** (code 0) increments A.
- **OP_ADDR** (code 1) adds A and B through the ripple adder.
- **OP_ADDO** (code 2) adds A and B through the operator.
- **OP_XOROR** (code 3) builds a split XOR/OR word.
- **OP_ANY** (code 4) tests whether any operand bit is set.
- **OP_PACK** (code 5) packs both operands into one byte.
- Codes 6 and 7 take the default branch.

Top module: `alu_board`

## Requirements
- R1: Function code 0 gives A+1, computed by the ripple adder with carry-in 1. The 5-bit sum sits in bits 4:0 and bits 7:5 are 0.
- R2: Function code 1 gives A+B, computed by the ripple adder with carry-in 0. The carry-out is bit 4 and bits 7:5 are 0.
- R3: Function code 2 gives A+B through the addition operator, zero-extended. It equals the code 1 result for every operand pair.
- R4: Function code 3 puts A XOR B in bits 3:0 and A OR B in bits 7:4.
- R5: Function code 4 gives 8'h01 when any bit of A or B is 1, and 8'h00 when all eight bits are 0.
- R6: Function code 5 gives A in bits 7:4 and B in bits 3:0.
- R7: Function codes 6 and 7 give 8'h00.
- R8: The function code is the bitwise inverse of key_n: a pressed button (0) sets its code bit to 1. With all buttons released, the code is 0.
- R9: hex0 shows B, hex2 shows A, hex4 shows result bits 3:0 and hex5 shows result bits 7:4. Each digit is active low with bit order {g,f,e,d,c,b,a}. The patterns for 0 to F are:

  | Digit | Pattern | Digit | Pattern |
  |---|---|---|---|
  | 0 | 1000000 | 8 | 0000000 |
  | 1 | 1111001 | 9 | 0010000 |
  | 2 | 0100100 | A | 0001000 |
  | 3 | 0110000 | b | 0000011 |
  | 4 | 0011001 | C | 1000110 |
  | 5 | 0010010 | d | 0100001 |
  | 6 | 0000010 | E | 0000110 |
  | 7 | 1111000 | F | 0001110 |

- R10: hex1 and hex3 always show the digit 0 (1000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| key_n | input | 3 | Active-low function buttons |
| result | output | 8 | ALU result |
| hex0 | output | 7 | Digit showing B |
| hex1 | output | 7 | Constant zero digit |
| hex2 | output | 7 | Digit showing A |
| hex3 | output | 7 | Constant zero digit |
| hex4 | output | 7 | Digit showing result low nibble |
| hex5 | output | 7 | Digit showing result high nibble |

## Verification
Some behaviours hold at every input change, and the assertions check these continuously:

- The ripple adder and the operator adder always agree.
- The code 4 result never has a bit above bit 0 set.
- Unused codes always produce zero.
- No digit is ever fully blank.

The exact value of each function and the digit patterns can only be shown by the bench's exhaustive sweep. That sweep covers all eight codes across all 256 operand pairs and compares each result against a behavioural model. The bench model also covers the button inversion and the constant digits.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_INC   = 3'd0,
        OP_ADDR  = 3'd1,
        OP_ADDO  = 3'd2,
        OP_XOROR = 3'd3,
        OP_ANY   = 3'd4,
        OP_PACK  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } alu_op_e;
endpackage

// File: rtl/alu_fa.sv
module alu_fa (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    // sum is odd parity, carry is the majority of the three inputs
    assign s    = x ^ y ^ cin;
    assign cout = (x & y) | (x & cin) | (y & cin);
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W:0] cy;

    assign cy[0] = cin;

    // each stage hands its carry to the next, least significant first
    for (genvar i = 0; i < W; i++) begin : g_stage
        alu_fa u_fa (
            .x   (x[i]),
            .y   (y[i]),
            .cin (cy[i]),
            .s   (s[i]),
            .cout(cy[i+1])
        );
    end

    assign cout = cy[W];
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [OPW-1:0] code,
    output logic [2*W-1:0] y
);
    localparam int RW  = 2 * W;
    localparam int PAD = RW - W - 1;

    logic [W-1:0] inc_s, add_s;
    logic         inc_c, add_c;
    logic [W:0]   sum_op;
    alu_op_e      op;

    // increment: A plus zero with carry-in 1
    alu_ripple #(.W(W)) u_inc (
        .x   (a),
        .y   ({W{1'b0}}),
        .cin (1'b1),
        .s   (inc_s),
        .cout(inc_c)
    );

    // add: A plus B with carry-in 0
    alu_ripple #(.W(W)) u_add (
        .x   (a),
        .y   (b),
        .cin (1'b0),
        .s   (add_s),
        .cout(add_c)
    );

    assign sum_op = {1'b0, a} + {1'b0, b};
    assign op     = alu_op_e'(code);

    // result multiplexer selected by the function code
    always_comb begin
        unique case (op)
            OP_INC:   y = {{PAD{1'b0}}, inc_c, inc_s};
            OP_ADDR:  y = {{PAD{1'b0}}, add_c, add_s};
            OP_ADDO:  y = {{PAD{1'b0}}, sum_op};
            OP_XOROR: y = {a | b, a ^ b};
            OP_ANY:   y = {{(RW-1){1'b0}}, |{a, b}};
            OP_PACK:  y = {a, b};
            default:  y = '0;
        endcase
    end

    always_comb begin
        // R3
        add_match_chk: assert ({add_c, add_s} == sum_op)
            else $error("ripple and operator sums disagree");
        // R1
        inc_chk: assert ({inc_c, inc_s} == ({1'b0, a} + 1'b1))
            else $error("increment path wrong");
        // R5
        any_width_chk: assert (op != OP_ANY || y[RW-1:1] == '0)
            else $error("any-bit result wider than one bit");
        // R7
        rsv_zero_chk: assert (!(op == OP_RSV6 || op == OP_RSV7) || y == '0)
            else $error("unused code result not zero");
    end
endmodule

// File: rtl/alu_hex7.sv
module alu_hex7 (
    input  logic [3:0] nib,
    output logic [6:0] seg
);
    // active-low segments, order {g,f,e,d,c,b,a}
    always_comb begin
        unique case (nib)
            4'h0: seg = 7'b1000000;
            4'h1: seg = 7'b1111001;
            4'h2: seg = 7'b0100100;
            4'h3: seg = 7'b0110000;
            4'h4: seg = 7'b0011001;
            4'h5: seg = 7'b0010010;
            4'h6: seg = 7'b0000010;
            4'h7: seg = 7'b1111000;
            4'h8: seg = 7'b0000000;
            4'h9: seg = 7'b0010000;
            4'hA: seg = 7'b0001000;
            4'hB: seg = 7'b0000011;
            4'hC: seg = 7'b1000110;
            4'hD: seg = 7'b0100001;
            4'hE: seg = 7'b0000110;
            default: seg = 7'b0001110;
        endcase
    end

    always_comb begin
        // R9
        seg_lit_chk: assert (seg != 7'h7F)
            else $error("digit fully blank");
    end
endmodule

// File: rtl/alu_board.sv
module alu_board
    import alu_pkg::*;
(
    input  logic [3:0] opa,
    input  logic [3:0] opb,
    input  logic [2:0] key_n,
    output logic [7:0] result,
    output logic [6:0] hex0,
    output logic [6:0] hex1,
    output logic [6:0] hex2,
    output logic [6:0] hex3,
    output logic [6:0] hex4,
    output logic [6:0] hex5
);
    localparam int W      = 4;
    localparam int NDIG   = 6;

    logic [OPW-1:0] code;
    logic [W-1:0]   nib [NDIG];
    logic [6:0]     seg [NDIG];

    // buttons read 1 when released
    assign code = ~key_n;

    alu_core #(.W(W)) u_core (
        .a   (opa),
        .b   (opb),
        .code(code),
        .y   (result)
    );

    assign nib[0] = opb;
    assign nib[1] = '0;
    assign nib[2] = opa;
    assign nib[3] = '0;
    assign nib[4] = result[W-1:0];
    assign nib[5] = result[2*W-1:W];

    for (genvar d = 0; d < NDIG; d++) begin : g_dig
        alu_hex7 u_hex (
            .nib(nib[d]),
            .seg(seg[d])
        );
    end

    assign hex0 = seg[0];
    assign hex1 = seg[1];
    assign hex2 = seg[2];
    assign hex3 = seg[3];
    assign hex4 = seg[4];
    assign hex5 = seg[5];
endmodule

// File: tb/sim_alu_board.sv
module sim_alu_board;
    logic       clk = 1'b0;
    logic [3:0] opa = '0;
    logic [3:0] opb = '0;
    logic [2:0] key_n = 3'b111;
    logic [7:0] result;
    logic [6:0] hex0, hex1, hex2, hex3, hex4, hex5;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    alu_board u0 (
        .opa(opa), .opb(opb), .key_n(key_n), .result(result),
        .hex0(hex0), .hex1(hex1), .hex2(hex2),
        .hex3(hex3), .hex4(hex4), .hex5(hex5)
    );

    function automatic logic [6:0] pat(input int v);
        case (v)
            0: return 7'b1000000;  1: return 7'b1111001;
            2: return 7'b0100100;  3: return 7'b0110000;
            4: return 7'b0011001;  5: return 7'b0010010;
            6: return 7'b0000010;  7: return 7'b1111000;
            8: return 7'b0000000;  9: return 7'b0010000;
            10: return 7'b0001000; 11: return 7'b0000011;
            12: return 7'b1000110; 13: return 7'b0100001;
            14: return 7'b0000110; default: return 7'b0001110;
        endcase
    endfunction

    function automatic int model(input int c, input int a, input int b);
        case (c)
            0: return a + 1;
            1: return a + b;
            2: return a + b;
            3: return ((a | b) * 16) + (a ^ b);
            4: return (a != 0 || b != 0) ? 1 : 0;
            5: return a * 16 + b;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        // reset-like state: all buttons released gives code 0 (A+1), R8
        @(negedge clk);
        opa = 4'd7; opb = 4'd3; key_n = 3'b111;
        @(posedge clk); #1;
        check("R8", result, 8);
        check("R10", hex1, pat(0));
        check("R10", hex3, pat(0));

        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    int e;
                    string rq;
                    @(negedge clk);
                    opa   = 4'(a);
                    opb   = 4'(b);
                    key_n = ~3'(c);
                    @(posedge clk); #1;
                    e = model(c, a, b);
                    case (c)
                        0: rq = "R1";
                        1: rq = "R2";
                        2: rq = "R3";
                        3: rq = "R4";
                        4: rq = "R5";
                        5: rq = "R6";
                        default: rq = "R7";
                    endcase
                    check(rq, result, e);
                    check("R9", {hex5, hex4, hex2, hex0},
                          {pat(e / 16), pat(e % 16), pat(a), pat(b)});
                    check("R10", {hex3, hex1}, {pat(0), pat(0)});
                end
            end
        end

        // corner points called out by the requirements
        @(negedge clk); opa = 4'hF; opb = 4'hF; key_n = ~3'd1;
        @(posedge clk); #1;
        check("R2", result, 8'h1E);
        @(negedge clk); opa = 4'hF; key_n = ~3'd0;
        @(posedge clk); #1;
        check("R1", result, 8'h10);
        @(negedge clk); opa = 4'h0; opb = 4'h0; key_n = ~3'd4;
        @(posedge clk); #1;
        check("R5", result, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule